// File: doc/BRIEF.md
# Transition Pulse Encoder with Periodic Level Refresh

This block drives the transmit side of a link that carries a single logic level across a barrier as short pulses rather than as a steady signal. It samples one asynchronous input bit, brings it into the local clock domain, and turns every change of level into a short pulse. A change from low to high makes a pulse on the set output. A change from high to low makes a pulse on the clear output. The receiving side keeps a bistable latch that these two pulse streams set and clear.

A pulse can be lost on its way across the barrier, so the block does not rely on transitions alone. While the input stays still, a timer runs. Each time the timer reaches its limit, the block sends a fresh pulse whose polarity matches the present level. This keeps correcting the receiver's latch. Every real transition restarts that timer. An edge that falls in the same cycle as a timer expiry wins.

Top module: `pulse_link_encoder`

## Requirements
- R1: A rising level on `data_in` that is held across a clock edge makes `set_pulse_o` go high at the (SYNC_STAGES+1)-th rising clock edge, counting the edge that first samples the new level as the first. With the default of two stages, that is the third edge.
- R2: A falling level on `data_in` makes `clr_pulse_o` go high with the same latency as R1.
- R3: Every pulse, whether from an edge or from a refresh, stays high for exactly PULSE_CYCLES clock cycles (default 1) and then returns low, unless R10 applies.
- R4: While the synchronized input stays constant, a refresh pulse starts every REFRESH_CYCLES cycles, counted from the start of the previous pulse. It appears on `set_pulse_o` when the level is 1 and on `clr_pulse_o` when the level is 0. Outside pulses, both outputs are low.
- R5: Every real transition restarts the refresh interval. The first refresh after an edge pulse starts exactly REFRESH_CYCLES cycles after that edge pulse started.
- R6: When an edge is detected in the same cycle that the refresh interval expires, only the edge pulse is sent, with the edge's polarity, and the interval restarts from that edge.
- R7: `set_pulse_o` and `clr_pulse_o` are never high in the same cycle.
- R8: While `rst` is high, both outputs are low. If the input stays low after `rst` falls, the first `clr_pulse_o` refresh pulse appears at the REFRESH_CYCLES-th rising clock edge after release.
- R9: A change on `data_in` that reverts before the next rising clock edge is never sampled and produces no pulse.
- R10: A new edge that arrives while a pulse is still high ends that pulse at once. The new pulse then starts with its own polarity and a full PULSE_CYCLES width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 1 | Asynchronous logic level to be encoded |
| set_pulse_o | output | 1 | Registered pulse for a rising level or a refresh of a high level |
| clr_pulse_o | output | 1 | Registered pulse for a falling level or a refresh of a low level |

## Verification
The two functions that can land in the same cycle are edge detection and expiry of the refresh interval. A sweep toggles the input after every gap from one cycle up to just over two refresh intervals. One of those gaps places a new edge exactly on a pending refresh. Other gaps shorter than the pulse width make edges cut into running pulses. In every cycle, the bench compares both outputs of a narrow-pulse instance and a wide-pulse instance against a schedule worked out arithmetically from the start time and polarity of the latest transition. At a collision, it expects a single pulse of the new polarity, followed by a refresh one full interval later.

// File: rtl/ple_pkg.sv
`timescale 1ns/1ps
package ple_pkg;
  // Kind of pulse requested of the shaper in a given cycle.
  typedef enum logic [1:0] {
    PEV_NONE = 2'd0,
    PEV_SET  = 2'd1,
    PEV_CLR  = 2'd2
  } pev_e;
endpackage

// File: rtl/ple_sync_edge.sv
`timescale 1ns/1ps
module ple_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  // Synchronizer chain, one flop per stage.
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain[STAGES-1];
  end

  assign level_o = chain[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;

  // An edge indication lasts exactly one cycle.
  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R1
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o); // R2
endmodule

// File: rtl/ple_refresh_timer.sv
`timescale 1ns/1ps
module ple_refresh_timer #(
  parameter int LIMIT = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + CW'(1);
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (cnt_q == '0)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST); // R4
endmodule

// File: rtl/ple_pulse_shaper.sv
`timescale 1ns/1ps
module ple_pulse_shaper
  import ple_pkg::*;
#(
  parameter int WIDTH = 1
) (
  input  logic clk,
  input  logic rst,
  input  pev_e ev_i,
  output logic set_o,
  output logic clr_o
);
  localparam int RW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [RW-1:0] HOLD = RW'(WIDTH - 1);

  logic [RW-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      set_o <= 1'b0;
      clr_o <= 1'b0;
      rem_q <= '0;
    end else if (ev_i != PEV_NONE) begin
      // A new request always replaces a running pulse.
      set_o <= (ev_i == PEV_SET);
      clr_o <= (ev_i == PEV_CLR);
      rem_q <= HOLD;
    end else if (rem_q != '0) begin
      rem_q <= rem_q - RW'(1);
    end else begin
      set_o <= 1'b0;
      clr_o <= 1'b0;
    end
  end

  AST_MUTEX: assert property (@(posedge clk) disable iff (rst)
    !(set_o && clr_o)); // R7
  AST_HOLD_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (ev_i == PEV_NONE && rem_q != '0) |=> ($stable(set_o) && $stable(clr_o))); // R3
endmodule

// File: rtl/pulse_link_encoder.sv
`timescale 1ns/1ps
module pulse_link_encoder
  import ple_pkg::*;
#(
  parameter int REFRESH_CYCLES = 250,
  parameter int PULSE_CYCLES   = 1,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic data_in,
  output logic set_pulse_o,
  output logic clr_pulse_o
);
  logic level, rise, fall, tick, any_edge;
  pev_e ev;

  ple_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(data_in),
    .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  assign any_edge = rise | fall;

  ple_refresh_timer #(.LIMIT(REFRESH_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .restart_i(any_edge), .tick_o(tick)
  );

  // An edge outranks a refresh request in the same cycle.
  always_comb begin
    if (rise)      ev = PEV_SET;
    else if (fall) ev = PEV_CLR;
    else if (tick) ev = level ? PEV_SET : PEV_CLR;
    else           ev = PEV_NONE;
  end

  ple_pulse_shaper #(.WIDTH(PULSE_CYCLES)) u_shaper (
    .clk(clk), .rst(rst), .ev_i(ev),
    .set_o(set_pulse_o), .clr_o(clr_pulse_o)
  );

  AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    rise |=> (set_pulse_o && !clr_pulse_o)); // R1
  AST_CLR_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    fall |=> (clr_pulse_o && !set_pulse_o)); // R2
  AST_EDGE_WINS_FALL: assert property (@(posedge clk) disable iff (rst)
    (fall && tick) |=> (clr_pulse_o && !set_pulse_o)); // R6
  AST_EDGE_WINS_RISE: assert property (@(posedge clk) disable iff (rst)
    (rise && tick) |=> (set_pulse_o && !clr_pulse_o)); // R6
  AST_REFRESH_HIGH: assert property (@(posedge clk) disable iff (rst)
    (tick && !any_edge && level) |=> (set_pulse_o && !clr_pulse_o)); // R4
  AST_REFRESH_LOW: assert property (@(posedge clk) disable iff (rst)
    (tick && !any_edge && !level) |=> (clr_pulse_o && !set_pulse_o)); // R4
endmodule

// File: tb/pulse_link_encoder_bench.sv
`timescale 1ns/1ps
module pulse_link_encoder_bench;
  localparam int N  = 16;
  localparam int PA = 1;
  localparam int PB = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic sa, ca, sb, cb;

  always #2 clk = ~clk;

  pulse_link_encoder #(.REFRESH_CYCLES(N), .PULSE_CYCLES(PA), .SYNC_STAGES(2)) u_pulse_link_encoder (
    .clk(clk), .rst(rst), .data_in(din), .set_pulse_o(sa), .clr_pulse_o(ca)
  );
  pulse_link_encoder #(.REFRESH_CYCLES(N), .PULSE_CYCLES(PB), .SYNC_STAGES(2)) u_wide (
    .clk(clk), .rst(rst), .data_in(din), .set_pulse_o(sb), .clr_pulse_o(cb)
  );

  int checks = 0;
  int errors = 0;
  int pc = 0;
  bit done = 0;
  bit glitch_win = 0;

  // Expected schedule: origins of pulse trains (start sample index, level, edge or reset).
  int ent_s [512];
  bit ent_l [512];
  bit ent_e [512];
  int n_ent = 0;

  function automatic void add_origin(input int s, input bit lv, input bit is_edge);
    while (n_ent > 0 && ent_s[n_ent-1] >= s) n_ent = n_ent - 1;
    ent_s[n_ent] = s;
    ent_l[n_ent] = lv;
    ent_e[n_ent] = is_edge;
    n_ent = n_ent + 1;
  endfunction

  function automatic void model(input int t, input int p,
                                output bit es, output bit ec, output string tg);
    int idx;
    int d;
    bit on;
    idx = -1;
    for (int i = 0; i < n_ent; i++) if (ent_s[i] <= t) idx = i;
    es = 1'b0;
    ec = 1'b0;
    tg = "R8";
    if (idx >= 0) begin
      d  = t - ent_s[idx];
      on = (d % N) < p;
      es = on && ent_l[idx];
      ec = on && !ent_l[idx];
      if (!ent_e[idx]) tg = "R8";
      else if (d < p) begin
        if (idx > 0 && ((ent_s[idx] - ent_s[idx-1]) % N) == 0) tg = "R6";
        else if (idx > 0 && (ent_s[idx] - ent_s[idx-1]) < p) tg = "R10";
        else if (d > 0) tg = "R3";
        else tg = ent_l[idx] ? "R1" : "R2";
      end
      else if (d < 2*N) tg = "R5";
      else tg = "R4";
    end
    if (glitch_win) tg = "R9";
  endfunction

  task automatic check_pair(input string name, input logic s, input logic c, input int p);
    bit es, ec;
    string tg;
    model(pc, p, es, ec, tg);
    checks = checks + 1;
    if (s !== es || c !== ec) begin
      errors = errors + 1;
      $display("FAIL %s %s cycle %0d: set/clr actual %b%b expected %b%b",
               tg, name, pc, s, c, es, ec);
    end
    checks = checks + 1;
    if (s === 1'b1 && c === 1'b1) begin
      errors = errors + 1;
      $display("FAIL R7 %s cycle %0d: set/clr actual 11 expected not both", name, pc);
    end
  endtask

  // Sample one time unit after each rising edge.
  always @(posedge clk) begin
    pc = pc + 1;
    #1;
    if (!done) begin
      check_pair("narrow", sa, ca, PA);
      check_pair("wide", sb, cb, PB);
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Change the level at a falling edge; its pulse appears at sample pc+3.
  task automatic toggle();
    din = ~din;
    add_origin(pc + 3, din, 1'b1);
  endtask

  // A level change that reverts before the next rising edge (R9).
  task automatic glitch();
    glitch_win = 1'b1;
    #0.5 din = ~din;
    #1   din = ~din;
    @(negedge clk);
    hold(8);
    glitch_win = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    din = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    add_origin(pc + N, 1'b0, 1'b0);   // R8: first refresh after release
    hold(3*N);
    toggle();                          // R1 then R4/R5 set refreshes
    hold(3*N);
    toggle();                          // R2 then clear refreshes
    hold(2*N);
    for (int g = 1; g <= 2*N + 3; g++) begin  // gaps incl. N (R6) and < PB (R10)
      toggle();
      hold(g);
    end
    hold(N - 5);
    toggle();                          // directed collision for R6
    hold(N);
    toggle();
    hold(2*N);
    for (int k = 0; k < 4; k++) glitch();
    hold(N);
    toggle();
    hold(N + 3);
    for (int k = 0; k < 3; k++) glitch();
    hold(2*N);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors = errors + 1;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule